// File: doc/BRIEF.md
# Link-Layer Block Receive Checker

This block sits behind a byte-wide serial front end and parses incoming link-layer blocks one byte at a time. It waits for an address byte that names this node as destination and the configured peer as source. It then takes the control byte and a two-byte length, most significant byte first. Next come that many information bytes, streamed out as they arrive. A two-byte frame check sequence closes the block.

When the block closes, the checker raises a one-cycle completion pulse. With it come the decoded block kind and its sequence, chaining, acknowledge or supervisory fields, the length, a good/bad flag and an error class. The error class separates a bad address byte, an illegal length, an unknown control code and a check-sequence mismatch.

Retransmission, chaining decisions and response generation are left to the layer above. The input always accepts bytes, so `in_ready` is held high. The check sequence is the 16-bit HDLC one: reflected polynomial 0x8408, seed 0xFFFF, result inverted. It covers the address byte through the last information byte and is sent low byte first.

States: HUNT (wait for an address byte), CTRL (control byte), LENH and LENL (length bytes), INFO (information bytes), FCSL and FCSH (trailer bytes). Transitions:
- HUNT goes to CTRL on a valid address byte. It stays in HUNT on 0x00 or on any other byte.
- CTRL goes to LENH.
- LENH goes to LENL.
- LENL goes back to HUNT on an illegal length, to FCSL on length zero, and to INFO otherwise.
- INFO goes to FCSL after the last information byte.
- FCSL goes to FCSH.
- FCSH goes back to HUNT.

Top module: `lbr_rx_checker`

## Requirements
- R1: After reset `blk_done`, `blk_ok` and `pay_valid` are low, `blk_err` is 0 and `blk_kind` is 3 (none).
- R2: A well-formed block whose control byte has bit 7 clear is reported as kind 0 (information), with `blk_seq` = bit 6, `blk_more` = bit 5, `blk_len` = the length field, `blk_ok` = 1 and `blk_err` = 0. The completion pulse comes in the cycle after the last trailer byte is accepted, and not earlier.
- R3: Each information byte appears on `pay_data` with `pay_valid` high in the cycle after it is accepted, in arrival order. Exactly `blk_len` such beats occur per block.
- R4: A 0x00 byte received in HUNT is dropped with no completion pulse, and the next block is parsed normally.
- R5: In HUNT, a nonzero byte is rejected if any of these holds: its high nibble (destination) is not `own_addr`, its low nibble (source) is not `peer_addr`, the two nibbles are equal, or either nibble is 0x0 or 0xF. A rejected byte gives a completion pulse with `blk_ok` = 0 and `blk_err` = 1, and hunting resumes with the next byte.
- R6: A length field above `max_inf` or above 4089 gives a completion pulse with `blk_err` = 2 in the cycle after the second length byte, and hunting resumes. A length equal to the cap (4089) is accepted.
- R7: A trailer that differs from the inverted check sequence gives `blk_ok` = 0 and `blk_err` = 4. This error takes priority over a control-code error.
- R8: A control byte with bits 7:5 = 100 is kind 1 (acknowledge), with `blk_seq` = bit 4 and `blk_rcode` = bits 1:0. An acknowledge code of 3, or a nonzero bit 3 or bit 2, gives `blk_err` = 3.
- R9: A control byte with bits 7:6 = 11 is kind 2 (supervisory), with `blk_sresp` = bit 5 and `blk_scode` = bits 4:0. Only codes 0x00, 0x01, 0x02, 0x03, 0x04, 0x06 and 0x0F are known; any other code gives `blk_err` = 3.
- R10: A block with length zero carries no information bytes. The trailer follows the length directly and the block is reported normally.
- R11: `blk_ok` is high on a completion pulse exactly when `blk_err` is 0. The pulse lasts one cycle unless the next accepted byte also ends a block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_data | input | 8 | Received byte |
| in_valid | input | 1 | Byte present |
| in_ready | output | 1 | Byte accepted (always high) |
| own_addr | input | 4 | This node's address nibble |
| peer_addr | input | 4 | Expected sender's address nibble |
| max_inf | input | LEN_W | Current information-size limit |
| blk_done | output | 1 | Block finished (pulse) |
| blk_ok | output | 1 | Finished block is valid |
| blk_err | output | 3 | 0 none, 1 address, 2 length, 3 control, 4 check sequence |
| blk_kind | output | 2 | 0 information, 1 acknowledge, 2 supervisory, 3 none |
| blk_seq | output | 1 | Send or receive sequence bit |
| blk_more | output | 1 | More-data flag of an information block |
| blk_rcode | output | 2 | Acknowledge code |
| blk_scode | output | 5 | Supervisory code |
| blk_sresp | output | 1 | Supervisory response flag |
| blk_len | output | LEN_W | Length field |
| pay_valid | output | 1 | Information byte out |
| pay_data | output | 8 | Information byte |

## Verification
Every result is registered once. The rules are:
- An address rejection shows in the cycle after the offending byte.
- A length rejection shows in the cycle after the second length byte.
- A payload beat shows in the cycle after its byte.
- The block verdict shows in the cycle after the high trailer byte.

The bench drives a byte and waits for the accepting clock edge, then samples one nanosecond later, inside exactly that cycle. It also watches every earlier byte for a stray completion pulse. It holds one idle cycle after each verdict so that the end of the pulse can be observed.

// File: rtl/lbr_pkg.sv
package lbr_pkg;

    typedef enum logic [2:0] {
        S_HUNT, S_CTRL, S_LENH, S_LENL, S_INFO, S_FCSL, S_FCSH
    } rx_state_t;

    localparam logic [1:0] K_INFO = 2'd0;
    localparam logic [1:0] K_RACK = 2'd1;
    localparam logic [1:0] K_SUP  = 2'd2;
    localparam logic [1:0] K_NONE = 2'd3;

    localparam logic [2:0] E_NONE = 3'd0;
    localparam logic [2:0] E_ADDR = 3'd1;
    localparam logic [2:0] E_LEN  = 3'd2;
    localparam logic [2:0] E_CTRL = 3'd3;
    localparam logic [2:0] E_FCS  = 3'd4;

    localparam logic [15:0] FCS_SEED = 16'hFFFF;
    localparam logic [15:0] FCS_POLY = 16'h8408;

    localparam int NUM_SCODES = 7;
    localparam logic [4:0] SCODE_LIST [NUM_SCODES] =
        '{5'h00, 5'h01, 5'h02, 5'h03, 5'h04, 5'h06, 5'h0F};

endpackage

// File: rtl/lbr_fcs16.sv
module lbr_fcs16
    import lbr_pkg::*;
(
    input  logic [15:0] fcs_in,
    input  logic [7:0]  din,
    output logic [15:0] fcs_out
);
    always_comb begin
        logic [15:0] c;
        c = fcs_in ^ {8'h00, din};
        for (int k = 0; k < 8; k++) begin
            c = c[0] ? ((c >> 1) ^ FCS_POLY) : (c >> 1);
        end
        fcs_out = c;
    end
endmodule

// File: rtl/lbr_ctrl_decode.sv
module lbr_ctrl_decode
    import lbr_pkg::*;
(
    input  logic [7:0] pcb,
    output logic [1:0] kind,
    output logic       seq,
    output logic       more,
    output logic [1:0] rcode,
    output logic [4:0] scode,
    output logic       sresp,
    output logic       bad
);
    logic [NUM_SCODES-1:0] hit;

    genvar g;
    generate
        for (g = 0; g < NUM_SCODES; g++) begin : g_scode
            assign hit[g] = (pcb[4:0] == SCODE_LIST[g]);
        end
    endgenerate

    always_comb begin
        kind  = K_NONE;
        seq   = 1'b0;
        more  = 1'b0;
        rcode = 2'd0;
        scode = 5'd0;
        sresp = 1'b0;
        bad   = 1'b0;
        if (!pcb[7]) begin
            kind = K_INFO;
            seq  = pcb[6];
            more = pcb[5];
        end else if (pcb[6:5] == 2'b00) begin
            kind  = K_RACK;
            seq   = pcb[4];
            rcode = pcb[1:0];
            bad   = (pcb[1:0] == 2'd3) || (pcb[3:2] != 2'd0);
        end else if (pcb[6]) begin
            kind  = K_SUP;
            sresp = pcb[5];
            scode = pcb[4:0];
            bad   = ~|hit;
        end else begin
            kind = K_NONE;
            bad  = 1'b1;
        end
    end
endmodule

// File: rtl/lbr_rx_checker.sv
module lbr_rx_checker
    import lbr_pkg::*;
#(
    parameter int LEN_W   = 16,
    parameter int LEN_CAP = 4089
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [7:0]       in_data,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [3:0]       own_addr,
    input  logic [3:0]       peer_addr,
    input  logic [LEN_W-1:0] max_inf,
    output logic             blk_done,
    output logic             blk_ok,
    output logic [2:0]       blk_err,
    output logic [1:0]       blk_kind,
    output logic             blk_seq,
    output logic             blk_more,
    output logic [1:0]       blk_rcode,
    output logic [4:0]       blk_scode,
    output logic             blk_sresp,
    output logic [LEN_W-1:0] blk_len,
    output logic             pay_valid,
    output logic [7:0]       pay_data
);
    localparam logic [LEN_W-1:0] CAP_V = LEN_W'(LEN_CAP);

    rx_state_t st, nxt;

    logic             acc;
    logic             addr_ok;
    logic [3:0]       dst_n, src_n;
    logic [LEN_W-1:0] len_word;
    logic             len_bad;
    logic [7:0]       len_hi_q;
    logic [LEN_W-1:0] len_q;
    logic [LEN_W-1:0] cnt_q;
    logic             last_info;
    logic [15:0]      fcs_q, fcs_seed_sel, fcs_nx;
    logic [7:0]       fcs_lo_q;
    logic             ctrl_bad_q;
    logic [15:0]      fcs_rx;

    logic [1:0] d_kind, d_rcode;
    logic       d_seq, d_more, d_sresp, d_bad;
    logic [4:0] d_scode;

    assign in_ready = 1'b1;
    assign acc      = in_valid & in_ready;

    assign dst_n   = in_data[7:4];
    assign src_n   = in_data[3:0];
    assign addr_ok = (dst_n != 4'h0) && (dst_n != 4'hF) &&
                     (src_n != 4'h0) && (src_n != 4'hF) &&
                     (dst_n != src_n) &&
                     (dst_n == own_addr) && (src_n == peer_addr);

    assign len_word  = {len_hi_q, in_data};
    assign len_bad   = (len_word > max_inf) || (len_word > CAP_V);
    assign last_info = (cnt_q + LEN_W'(1)) == len_q;
    assign fcs_rx    = {in_data, fcs_lo_q};

    assign fcs_seed_sel = (st == S_HUNT) ? FCS_SEED : fcs_q;

    lbr_fcs16 u_fcs (
        .fcs_in  (fcs_seed_sel),
        .din     (in_data),
        .fcs_out (fcs_nx)
    );

    lbr_ctrl_decode u_dec (
        .pcb   (in_data),
        .kind  (d_kind),
        .seq   (d_seq),
        .more  (d_more),
        .rcode (d_rcode),
        .scode (d_scode),
        .sresp (d_sresp),
        .bad   (d_bad)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) st <= S_HUNT;
        else        st <= nxt;
    end

    // next-state logic
    always_comb begin
        nxt = st;
        if (acc) begin
            unique case (st)
                S_HUNT: if (in_data != 8'h00 && addr_ok) nxt = S_CTRL;
                S_CTRL: nxt = S_LENH;
                S_LENH: nxt = S_LENL;
                S_LENL: begin
                    if (len_bad)                  nxt = S_HUNT;
                    else if (len_word == '0)      nxt = S_FCSL;
                    else                          nxt = S_INFO;
                end
                S_INFO: if (last_info) nxt = S_FCSL;
                S_FCSL: nxt = S_FCSH;
                S_FCSH: nxt = S_HUNT;
                default: nxt = S_HUNT;
            endcase
        end
    end

    // datapath and outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            blk_done   <= 1'b0;
            blk_ok     <= 1'b0;
            blk_err    <= E_NONE;
            blk_kind   <= K_NONE;
            blk_seq    <= 1'b0;
            blk_more   <= 1'b0;
            blk_rcode  <= 2'd0;
            blk_scode  <= 5'd0;
            blk_sresp  <= 1'b0;
            blk_len    <= '0;
            pay_valid  <= 1'b0;
            pay_data   <= 8'h00;
            len_hi_q   <= 8'h00;
            len_q      <= '0;
            cnt_q      <= '0;
            fcs_q      <= FCS_SEED;
            fcs_lo_q   <= 8'h00;
            ctrl_bad_q <= 1'b0;
        end else begin
            blk_done  <= 1'b0;
            pay_valid <= 1'b0;
            if (acc) begin
                unique case (st)
                    S_HUNT: begin
                        if (in_data != 8'h00) begin
                            if (addr_ok) begin
                                fcs_q <= fcs_nx;
                            end else begin
                                blk_done <= 1'b1;
                                blk_ok   <= 1'b0;
                                blk_err  <= E_ADDR;
                            end
                        end
                    end
                    S_CTRL: begin
                        fcs_q      <= fcs_nx;
                        blk_kind   <= d_kind;
                        blk_seq    <= d_seq;
                        blk_more   <= d_more;
                        blk_rcode  <= d_rcode;
                        blk_scode  <= d_scode;
                        blk_sresp  <= d_sresp;
                        ctrl_bad_q <= d_bad;
                    end
                    S_LENH: begin
                        fcs_q    <= fcs_nx;
                        len_hi_q <= in_data;
                    end
                    S_LENL: begin
                        fcs_q   <= fcs_nx;
                        blk_len <= len_word;
                        len_q   <= len_word;
                        cnt_q   <= '0;
                        if (len_bad) begin
                            blk_done <= 1'b1;
                            blk_ok   <= 1'b0;
                            blk_err  <= E_LEN;
                        end
                    end
                    S_INFO: begin
                        fcs_q     <= fcs_nx;
                        cnt_q     <= cnt_q + LEN_W'(1);
                        pay_valid <= 1'b1;
                        pay_data  <= in_data;
                    end
                    S_FCSL: fcs_lo_q <= in_data;
                    S_FCSH: begin
                        blk_done <= 1'b1;
                        if (fcs_rx != ~fcs_q) begin
                            blk_ok  <= 1'b0;
                            blk_err <= E_FCS;
                        end else if (ctrl_bad_q) begin
                            blk_ok  <= 1'b0;
                            blk_err <= E_CTRL;
                        end else begin
                            blk_ok  <= 1'b1;
                            blk_err <= E_NONE;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/lbr_rx_checker_sva.sv
module lbr_rx_checker_sva
    import lbr_pkg::*;
#(
    parameter int LEN_W   = 16,
    parameter int LEN_CAP = 4089
) (
    input logic             clk,
    input logic             rst_n,
    input rx_state_t        st,
    input logic             in_valid,
    input logic [7:0]       in_data,
    input logic [LEN_W-1:0] max_inf,
    input logic             blk_done,
    input logic             blk_ok,
    input logic [2:0]       blk_err,
    input logic [1:0]       blk_kind,
    input logic [1:0]       blk_rcode,
    input logic [LEN_W-1:0] blk_len,
    input logic             pay_valid
);
    AST_NULL_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_HUNT && in_valid && in_data == 8'h00) |=> !blk_done); // R4

    AST_PAY_AFTER_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
        pay_valid |-> $past(in_valid)); // R3

    AST_ADDR_REJECT_HUNTS: assert property (@(posedge clk) disable iff (!rst_n)
        (blk_done && blk_err == E_ADDR) |-> st == S_HUNT); // R5

    AST_LEN_WITHIN_LIMITS: assert property (@(posedge clk) disable iff (!rst_n)
        (blk_done && blk_ok) |-> (blk_len <= LEN_W'(LEN_CAP) && blk_len <= max_inf)); // R6

    AST_OK_MEANS_NO_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        blk_done |-> (blk_ok == (blk_err == E_NONE))); // R11

    AST_RACK_CODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        (blk_done && blk_ok && blk_kind == K_RACK) |-> blk_rcode != 2'd3); // R8
endmodule

bind lbr_rx_checker lbr_rx_checker_sva #(.LEN_W(LEN_W), .LEN_CAP(LEN_CAP)) u_sva (
    .clk       (clk),
    .rst_n     (rst_n),
    .st        (st),
    .in_valid  (in_valid),
    .in_data   (in_data),
    .max_inf   (max_inf),
    .blk_done  (blk_done),
    .blk_ok    (blk_ok),
    .blk_err   (blk_err),
    .blk_kind  (blk_kind),
    .blk_rcode (blk_rcode),
    .blk_len   (blk_len),
    .pay_valid (pay_valid)
);

// File: tb/lbr_rx_checker_test.sv
`timescale 1ns/1ps
module lbr_rx_checker_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  in_data = 8'h00;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [3:0]  own_addr = 4'h1;
    logic [3:0]  peer_addr = 4'h2;
    logic [15:0] max_inf = 16'd254;
    logic        blk_done, blk_ok, blk_seq, blk_more, blk_sresp, pay_valid;
    logic [2:0]  blk_err;
    logic [1:0]  blk_kind, blk_rcode;
    logic [4:0]  blk_scode;
    logic [15:0] blk_len;
    logic [7:0]  pay_data;

    int n_chk = 0;
    int n_bad = 0;
    int early = 0;
    logic [7:0] pq[$];

    always #2 clk = ~clk;

    lbr_rx_checker uut (
        .clk(clk), .rst_n(rst_n), .in_data(in_data), .in_valid(in_valid),
        .in_ready(in_ready), .own_addr(own_addr), .peer_addr(peer_addr),
        .max_inf(max_inf), .blk_done(blk_done), .blk_ok(blk_ok),
        .blk_err(blk_err), .blk_kind(blk_kind), .blk_seq(blk_seq),
        .blk_more(blk_more), .blk_rcode(blk_rcode), .blk_scode(blk_scode),
        .blk_sresp(blk_sresp), .blk_len(blk_len), .pay_valid(pay_valid),
        .pay_data(pay_data)
    );

    task automatic chk(input bit cond, input string tag, input int act, input int exp);
        n_chk++;
        if (!cond) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] fcs_step(input logic [15:0] c, input logic [7:0] b);
        logic [15:0] r;
        r = c ^ {8'h00, b};
        for (int k = 0; k < 8; k++) r = r[0] ? ((r >> 1) ^ 16'h8408) : (r >> 1);
        return r;
    endfunction

    task automatic put(input logic [7:0] b);
        in_data  = b;
        in_valid = 1'b1;
        @(posedge clk);
        #1;
        in_valid = 1'b0;
        if (pay_valid) pq.push_back(pay_data);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic run_block(input logic [7:0] a, input logic [7:0] pcb,
                             input int len, input bit badfcs);
        logic [7:0]  fr[$];
        logic [15:0] c;
        logic [15:0] f;
        fr = {};
        fr.push_back(a);
        fr.push_back(pcb);
        fr.push_back(8'(len >> 8));
        fr.push_back(8'(len));
        for (int i = 0; i < len; i++) fr.push_back(8'(8'hA0 + i));
        c = 16'hFFFF;
        foreach (fr[i]) c = fcs_step(c, fr[i]);
        f = ~c;
        if (badfcs) f = f ^ 16'h0001;
        fr.push_back(f[7:0]);
        fr.push_back(f[15:8]);
        pq = {};
        early = 0;
        foreach (fr[i]) begin
            put(fr[i]);
            if (i < fr.size() - 1 && blk_done) early++;
        end
    endtask

    task automatic check_pulse_ends(input string tag);
        idle(1);
        chk(blk_done == 1'b0, tag, blk_done, 0);
    endtask

    task automatic t_reset;
        chk(blk_done == 0 && pay_valid == 0 && blk_ok == 0, "R1 idle outputs",
            {blk_done, pay_valid, blk_ok}, 0);
        chk(blk_err == 3'd0 && blk_kind == 2'd3, "R1 err/kind", {blk_err, blk_kind}, 3);
    endtask

    task automatic t_iblock;
        run_block(8'h12, 8'h60, 3, 1'b0);
        chk(early == 0, "R2 no early done", early, 0);
        chk(blk_done && blk_ok && blk_err == 0, "R2 verdict", {blk_done, blk_ok, blk_err}, 6'h18);
        chk(blk_kind == 0 && blk_seq && blk_more && blk_len == 3, "R2 fields",
            {blk_kind, blk_seq, blk_more, blk_len}, {2'd0, 2'b11, 16'd3});
        chk(pq.size() == 3, "R3 beat count", pq.size(), 3);
        for (int i = 0; i < pq.size() && i < 3; i++)
            chk(pq[i] == 8'(8'hA0 + i), "R3 payload order", pq[i], 8'hA0 + i);
        check_pulse_ends("R11 pulse ends");
    endtask

    task automatic t_rblock_empty;
        run_block(8'h12, 8'h91, 0, 1'b0);
        chk(blk_done && blk_ok && pq.size() == 0, "R10 empty block", {blk_done, blk_ok, pq.size()}, 3);
        chk(blk_kind == 1 && blk_seq == 1 && blk_rcode == 1 && blk_len == 0, "R8 ack fields",
            {blk_kind, blk_seq, blk_rcode}, {2'd1, 1'b1, 2'd1});
        idle(1);
    endtask

    task automatic t_sblock;
        run_block(8'h12, 8'hE3, 1, 1'b0);
        chk(blk_done && blk_ok && blk_kind == 2 && blk_scode == 5'h03 && blk_sresp,
            "R9 supervisory", {blk_done, blk_ok, blk_kind, blk_scode, blk_sresp}, 0);
        idle(1);
        run_block(8'h12, 8'hCF, 0, 1'b0);
        chk(blk_done && blk_ok && blk_scode == 5'h0F && !blk_sresp, "R9 code 0F",
            {blk_ok, blk_scode}, 8'h2F);
        idle(1);
        run_block(8'h12, 8'hC5, 0, 1'b0);
        chk(blk_done && !blk_ok && blk_err == 3, "R9 unknown code", blk_err, 3);
        idle(1);
    endtask

    task automatic t_rbad;
        run_block(8'h12, 8'h83, 0, 1'b0);
        chk(blk_done && !blk_ok && blk_err == 3, "R8 ack code 3", blk_err, 3);
        idle(1);
    endtask

    task automatic t_fcs;
        run_block(8'h12, 8'h00, 2, 1'b1);
        chk(blk_done && !blk_ok && blk_err == 4, "R7 fcs mismatch", blk_err, 4);
        idle(1);
        run_block(8'h12, 8'hC5, 0, 1'b1);
        chk(blk_done && blk_err == 4, "R7 fcs over ctrl", blk_err, 4);
        idle(1);
    endtask

    task automatic t_null;
        put(8'h00);
        chk(blk_done == 0, "R4 null dropped", blk_done, 0);
        put(8'h00);
        chk(blk_done == 0, "R4 second null", blk_done, 0);
        run_block(8'h12, 8'h00, 1, 1'b0);
        chk(blk_done && blk_ok && early == 0, "R4 block after nulls", {blk_done, blk_ok}, 3);
        idle(1);
    endtask

    task automatic t_addr;
        put(8'h11);
        chk(blk_done && !blk_ok && blk_err == 1, "R5 equal nibbles", blk_err, 1);
        put(8'h21);
        chk(blk_done && blk_err == 1, "R5 wrong direction", blk_err, 1);
        put(8'hF2);
        chk(blk_done && blk_err == 1, "R5 nibble F", blk_err, 1);
        run_block(8'h12, 8'h40, 2, 1'b0);
        chk(blk_done && blk_ok && blk_seq && early == 0, "R5 resync", {blk_done, blk_ok}, 3);
        idle(1);
    endtask

    task automatic t_len;
        max_inf = 16'd8;
        put(8'h12); put(8'h00); put(8'h00); put(8'h09);
        chk(blk_done && !blk_ok && blk_err == 2, "R6 over limit", blk_err, 2);
        idle(1);
        run_block(8'h12, 8'h00, 8, 1'b0);
        chk(blk_done && blk_ok && blk_len == 8, "R6 at limit", blk_len, 8);
        idle(1);
        max_inf = 16'hFFFF;
        put(8'h12); put(8'h00); put(8'h0F); put(8'hFA);
        chk(blk_done && blk_err == 2, "R6 over cap", blk_err, 2);
        idle(1);
        run_block(8'h12, 8'h00, 4089, 1'b0);
        chk(blk_done && blk_ok && blk_len == 16'd4089 && pq.size() == 4089,
            "R6 at cap", blk_len, 4089);
        idle(1);
        max_inf = 16'd254;
    endtask

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(1);
        t_reset();
        t_iblock();
        t_rblock_empty();
        t_sblock();
        t_rbad();
        t_fcs();
        t_null();
        t_addr();
        t_len();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(4 * 150000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule